// File: doc/BRIEF.md
# CAN Bit Timing Sampler

This block turns a raw CAN receive line into one sampled bit per nominal bit time. A programmable prescaler divides the system clock into time quanta. Each bit is built from a one-quantum sync segment, a first phase segment that ends at the sample point, and a second phase segment that ends at the transmit point. While the bus is idle, the first recessive-to-dominant transition starts a bit. Later transitions move the bit boundaries to follow the sending node's clock: segment 1 is stretched for late edges and segment 2 is cut short for early ones, in both cases by at most the jump width.

At the sample point the block emits the bit value with a one-cycle strobe. At the transmit point it emits a one-cycle strobe that a transmitter can use to launch its next bit. An optional mode replaces the single sample with a majority vote over three consecutive quanta, which suppresses short spikes on slow buses. Frame decoding, stuffing, arbitration and error handling live outside this block.

Top module: `can_bit_timer`

## Requirements
- R1: Configuration fields hold the desired value minus one. The quantum is `cfg_brp`+1 clock cycles, segment 1 is `cfg_tseg1`+1 quanta (1 to 16), segment 2 is `cfg_tseg2`+1 quanta (1 to 8) and the jump width is `cfg_sjw`+1 quanta (1 to 4). A bit without phase correction lasts 1+S1+S2 quanta, with a sync segment of exactly one quantum.
- R2: The line level 1 is recessive and 0 is dominant. While idle, a 1-to-0 change of `rx_raw` that is present before rising edge n hard-synchronizes the block. The sync quantum then starts at edge n+1, the sample point falls at edge n+1+(1+S1)*Q and the transmit point at edge n+1+(1+S1+S2)*Q, where Q is the quantum length in clocks.
- R3: `rx_bit_valid` is high for exactly the one cycle after each sample-point edge. `rx_bit` changes only together with that strobe. With triple sampling off, `rx_bit` takes the `rx_raw` level registered on the clock edge just before the sample-point edge.
- R4: `tx_point` is high for exactly one cycle after the edge that ends segment 2 and never together with `rx_bit_valid`. Exactly one transmit point falls between two sample points of consecutive bits.
- R5: A falling edge first registered in quantum k of segment 1 (k counted from 1) lengthens segment 1 of that bit by min(k, SJW) quanta. A falling edge inside the sync quantum changes nothing.
- R6: A falling edge first registered in segment 2 leaves e quanta of segment 2, counting the current quantum. If e is at most SJW, the bit ends at once: `tx_point` follows on the next edge and a new sync quantum starts there. Otherwise segment 2 is shortened by SJW quanta.
- R7: At most one resynchronization happens between two sample points, and a hard sync counts as that one. Further falling edges are ignored until the next sample point, and rising edges never move the timing.
- R8: With `cfg_triple` set, the bit is the majority of the line levels taken at the last three quantum ticks, ending at the sample point.
- R9: After reset, and after IDLE_BITS consecutive recessive samples, the block is idle. It emits no strobes until a falling edge hard-synchronizes it again. The sample that completes the recessive run still gets its `rx_bit_valid`, but no transmit point follows it.
- R10: During and right after reset, `rx_bit` is 1 and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_raw | input | 1 | Receive line, 1 recessive, 0 dominant |
| cfg_brp | input | PRE_W | Prescaler, clocks per quantum minus one |
| cfg_tseg1 | input | 4 | Segment 1 length minus one |
| cfg_tseg2 | input | 3 | Segment 2 length minus one |
| cfg_sjw | input | 2 | Jump width minus one |
| cfg_triple | input | 1 | Majority of three samples when 1 |
| rx_bit | output | 1 | Last sampled bit value |
| rx_bit_valid | output | 1 | One-cycle strobe after each sample point |
| tx_point | output | 1 | One-cycle strobe at the transmit point |

## Verification
The bench sweeps every segment length at three prescaler values and compares the clock positions of the sample and transmit strobes with 1+S1+S2 quanta. An off-by-one in the field decoding or in the sync quantum shifts every one of these positions. Late and early edges are placed in each quantum of the segment they fall in, for every jump width. A design that clamps wrongly, measures the phase error from the wrong origin, or shrinks instead of restarting when the error fits the jump width lands its strobes on the wrong clock. Spikes of one and two quanta at each of the three voting positions separate single sampling from majority voting. Glitches placed after a hard sync, and after an early restart, expose a design that resynchronizes twice before one sample point. A long recessive run checks that the strobes stop after exactly IDLE_BITS samples and that the next falling edge restarts the timing.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int PRE_W     = 6,
  parameter int IDLE_BITS = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_raw,
  input  logic [PRE_W-1:0] cfg_brp,
  input  logic [3:0]       cfg_tseg1,
  input  logic [2:0]       cfg_tseg2,
  input  logic [1:0]       cfg_sjw,
  input  logic             cfg_triple,
  output logic             rx_bit,
  output logic             rx_bit_valid,
  output logic             tx_point
);
  localparam int CW = $clog2(IDLE_BITS + 1);

  typedef enum logic [1:0] {ST_SYNC, ST_SEG1, ST_SEG2} phase_t;

  logic             rx_q, rx_d;
  logic [PRE_W-1:0] pcnt;
  phase_t           seg;
  logic [4:0]       qcnt;
  logic [2:0]       ext, shr;
  logic             rs_done, idle;
  logic [1:0]       hist;
  logic [CW-1:0]    rec_cnt;

  logic [4:0] seg1_len, seg1_end, late_err;
  logic [3:0] seg2_len, seg2_end, early_err;
  logic [2:0] sjw_len, late_amt, ext_n, shr_n;
  logic       tick, fall, resync, early_now, maj, go_idle;

  assign seg1_len = {1'b0, cfg_tseg1} + 5'd1;
  assign seg2_len = {1'b0, cfg_tseg2} + 4'd1;
  assign sjw_len  = {1'b0, cfg_sjw} + 3'd1;

  assign tick   = (pcnt == cfg_brp);
  assign fall   = rx_d & ~rx_q;
  assign resync = fall & ~idle & ~rs_done & (seg != ST_SYNC);

  assign late_err  = qcnt + 5'd1;
  assign late_amt  = (late_err > {2'b00, sjw_len}) ? sjw_len : late_err[2:0];
  assign early_err = seg2_len - qcnt[3:0];
  assign early_now = resync & (seg == ST_SEG2) & (early_err <= {1'b0, sjw_len});

  assign ext_n = (resync && seg == ST_SEG1) ? late_amt : ext;
  assign shr_n = (resync && seg == ST_SEG2 && !early_now) ? sjw_len : shr;

  assign seg1_end = seg1_len + {2'b00, ext_n} - 5'd1;
  assign seg2_end = seg2_len - {1'b0, shr_n} - 4'd1;

  assign maj     = cfg_triple ? ((hist[1] & hist[0]) | (hist[1] & rx_q) | (hist[0] & rx_q)) : rx_q;
  assign go_idle = maj && (rec_cnt == CW'(IDLE_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q         <= 1'b1;
      rx_d         <= 1'b1;
      pcnt         <= '0;
      seg          <= ST_SYNC;
      qcnt         <= '0;
      ext          <= '0;
      shr          <= '0;
      rs_done      <= 1'b0;
      idle         <= 1'b1;
      hist         <= 2'b11;
      rec_cnt      <= '0;
      rx_bit       <= 1'b1;
      rx_bit_valid <= 1'b0;
      tx_point     <= 1'b0;
    end else begin
      rx_q         <= rx_raw;
      rx_d         <= rx_q;
      rx_bit_valid <= 1'b0;
      tx_point     <= 1'b0;
      if (idle) begin
        if (fall) begin
          idle    <= 1'b0;
          pcnt    <= '0;
          seg     <= ST_SYNC;
          qcnt    <= '0;
          ext     <= '0;
          shr     <= '0;
          rs_done <= 1'b1;
          rec_cnt <= '0;
        end
      end else if (early_now) begin
        pcnt     <= '0;
        seg      <= ST_SYNC;
        qcnt     <= '0;
        ext      <= '0;
        shr      <= '0;
        rs_done  <= 1'b1;
        tx_point <= 1'b1;
      end else begin
        pcnt <= tick ? '0 : pcnt + 1'b1;
        ext  <= ext_n;
        shr  <= shr_n;
        if (resync) rs_done <= 1'b1;
        if (tick) begin
          hist <= {hist[0], rx_q};
          case (seg)
            ST_SYNC: begin
              seg  <= ST_SEG1;
              qcnt <= '0;
            end
            ST_SEG1: begin
              if (qcnt == seg1_end) begin
                seg          <= go_idle ? ST_SYNC : ST_SEG2;
                qcnt         <= '0;
                ext          <= '0;
                rs_done      <= 1'b0;
                rx_bit       <= maj;
                rx_bit_valid <= 1'b1;
                rec_cnt      <= (!maj || go_idle) ? '0 : rec_cnt + 1'b1;
                if (go_idle) idle <= 1'b1;
              end else begin
                qcnt <= qcnt + 5'd1;
              end
            end
            ST_SEG2: begin
              if (qcnt == {1'b0, seg2_end}) begin
                seg      <= ST_SYNC;
                qcnt     <= '0;
                shr      <= '0;
                tx_point <= 1'b1;
              end else begin
                qcnt <= qcnt + 5'd1;
              end
            end
            default: seg <= ST_SYNC;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_raw,
  input logic cfg_triple,
  input logic rx_bit,
  input logic rx_bit_valid,
  input logic tx_point
);
  logic [1:0] tx_since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_since <= '0;
    else if (rx_bit_valid) tx_since <= '0;
    else if (tx_point && tx_since != 2'd3) tx_since <= tx_since + 2'd1;
  end

  // R3
  valid_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bit_valid |=> !rx_bit_valid);

  // R3
  bit_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_bit_valid |-> $stable(rx_bit));

  // R3
  direct_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_bit_valid && !$past(cfg_triple)) |-> (rx_bit == $past(rx_raw, 2)));

  // R4
  tx_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_point |=> !tx_point);

  // R4
  strobe_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_bit_valid && tx_point));

  // R4
  one_tx_per_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_point |-> (tx_since == 2'd0));

  // R4
  tx_before_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bit_valid |-> (tx_since <= 2'd1));
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_raw(rx_raw), .cfg_triple(cfg_triple),
  .rx_bit(rx_bit), .rx_bit_valid(rx_bit_valid), .tx_point(tx_point)
);

// File: tb/can_bit_timer_test.sv
module can_bit_timer_test;
  localparam int PW   = 6;
  localparam int IDLE = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic [PW-1:0] brp = '0;
  logic [3:0] s1f = '0;
  logic [2:0] s2f = '0;
  logic [1:0] sjf = '0;
  logic trip = 1'b0;
  logic rx_bit, rx_bit_valid, tx_point;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int sv_cyc[64];
  int sv_val[64];
  int tx_cyc[64];
  int nsv = 0;
  int ntx = 0;

  can_bit_timer #(.PRE_W(PW), .IDLE_BITS(IDLE)) uut (
    .clk(clk), .rst_n(rst_n), .rx_raw(rx), .cfg_brp(brp), .cfg_tseg1(s1f),
    .cfg_tseg2(s2f), .cfg_sjw(sjf), .cfg_triple(trip),
    .rx_bit(rx_bit), .rx_bit_valid(rx_bit_valid), .tx_point(tx_point)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rx_bit_valid && nsv < 64) begin
      sv_cyc[nsv] = cyc;
      sv_val[nsv] = int'(rx_bit);
      nsv = nsv + 1;
    end
    if (tx_point && ntx < 64) begin
      tx_cyc[ntx] = cyc;
      ntx = ntx + 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start(int b, int s1, int s2, int sj, bit tr);
    @(negedge clk);
    rst_n = 1'b0;
    rx = 1'b1;
    brp = PW'(b);
    s1f = 4'(s1 - 1);
    s2f = 3'(s2 - 1);
    sjf = 2'(sj - 1);
    trip = tr;
    @(posedge clk);
    nsv = 0;
    ntx = 0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic fall_now(output int b0);
    rx = 1'b0;
    b0 = cyc + 2;
  endtask

  task automatic drive_before(int e, bit v);
    while (cyc < e - 1) @(negedge clk);
    rx = v;
  endtask

  task automatic wait_to(int e);
    while (cyc < e + 1) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int b0, b1, bs, b2, q, t, x, e, tx1, sp;

    // R10 reset state, R9 no strobes while idle
    @(negedge clk);
    chk("R10 rx_bit in reset", int'(rx_bit), 1);
    chk("R10 valid in reset", int'(rx_bit_valid), 0);
    chk("R10 tx in reset", int'(tx_point), 0);
    start(0, 2, 2, 1, 1'b0);
    repeat (40) @(negedge clk);
    chk("R9 no samples before sync", nsv, 0);
    chk("R9 no tx before sync", ntx, 0);
    chk("R10 rx_bit after reset", int'(rx_bit), 1);

    // R1 R2 R3 R4 full sweep of segment lengths
    for (int b = 0; b < 3; b++)
      for (int s1 = 1; s1 <= 16; s1++)
        for (int s2 = 1; s2 <= 8; s2++) begin
          q = b + 1;
          t = 1 + s1 + s2;
          start(b, s1, s2, 1, 1'b0);
          fall_now(b0);
          drive_before(b0 + t * q, 1'b1);
          wait_to(b0 + t * q + (1 + s1) * q);
          chk("R3 sample count", nsv, 2);
          chk("R2 first sample edge", sv_cyc[0], b0 + (1 + s1) * q);
          chk("R3 first value", sv_val[0], 0);
          chk("R4 tx count", ntx, 1);
          chk("R1 transmit edge", tx_cyc[0], b0 + t * q);
          chk("R1 second sample edge", sv_cyc[1], b0 + t * q + (1 + s1) * q);
          chk("R3 second value", sv_val[1], 1);
        end

    // R5 late edges
    foreach (sv_val[i]) sv_val[i] = 0;
    for (int s1i = 0; s1i < 2; s1i++)
      for (int sj = 1; sj <= 4; sj++) begin
        int s1;
        s1 = (s1i == 0) ? 3 : 8;
        for (int j = 0; j <= s1; j++) begin
          q = 2;
          t = 1 + s1 + 4;
          x = (j == 0) ? 0 : ((j < sj) ? j : sj);
          start(1, s1, 4, sj, 1'b0);
          fall_now(b0);
          b1 = b0 + t * q;
          drive_before(b1, 1'b1);
          b2 = b1 + t * q;
          drive_before(b2 + j * q, 1'b0);
          sp = b2 + (1 + s1 + x) * q;
          wait_to(sp + 4 * q);
          chk("R5 late sample edge", sv_cyc[2], sp);
          chk("R5 late value", sv_val[2], 0);
          chk("R5 late transmit edge", tx_cyc[2], sp + 4 * q);
        end
      end

    // R6 early edges
    for (int s2i = 0; s2i < 2; s2i++)
      for (int sj = 1; sj <= 4; sj++) begin
        int s2;
        s2 = (s2i == 0) ? 2 : 8;
        for (int qq = 0; qq < s2; qq++) begin
          q = 2;
          t = 1 + 4 + s2;
          start(1, 4, s2, sj, 1'b0);
          fall_now(b0);
          b1 = b0 + t * q;
          drive_before(b1, 1'b1);
          bs = b1 + 5 * q;
          drive_before(bs + qq * q, 1'b0);
          e = s2 - qq;
          tx1 = (e <= sj) ? (bs + qq * q + 1) : (bs + (s2 - sj) * q);
          sp = tx1 + 5 * q;
          wait_to(sp);
          chk("R6 early transmit edge", tx_cyc[1], tx1);
          chk("R6 tx count", ntx, 2);
          chk("R6 bit1 value", sv_val[1], 1);
          chk("R6 next sample edge", sv_cyc[2], sp);
          chk("R6 next value", sv_val[2], 0);
        end
      end

    // R7 glitch after hard sync is ignored
    start(1, 6, 3, 4, 1'b0);
    fall_now(b0);
    drive_before(b0 + 4, 1'b1);
    drive_before(b0 + 6, 1'b0);
    wait_to(b0 + 14);
    chk("R7 sample after hard sync glitch", sv_cyc[0], b0 + 14);
    chk("R7 value after hard sync glitch", sv_val[0], 0);

    // R7 glitch after an early restart is ignored
    start(1, 6, 4, 4, 1'b0);
    fall_now(b0);
    b1 = b0 + 11 * 2;
    drive_before(b1, 1'b1);
    bs = b1 + 7 * 2;
    drive_before(bs + 2 * 2, 1'b0);
    b2 = bs + 4 + 1;
    drive_before(b2 + 4, 1'b1);
    drive_before(b2 + 6, 1'b0);
    wait_to(b2 + 14);
    chk("R7 restart transmit edge", tx_cyc[1], b2);
    chk("R7 sample after second glitch", sv_cyc[2], b2 + 14);
    chk("R7 value after second glitch", sv_val[2], 0);

    // R8 majority voting, Q=1, S1=5: votes on quanta 3,4,5
    for (int c = 0; c < 6; c++) begin
      int j0, j1, expv;
      bit tr;
      case (c)
        0: begin tr = 0; j0 = 5; j1 = 5; expv = 1; end
        1: begin tr = 1; j0 = 5; j1 = 5; expv = 0; end
        2: begin tr = 1; j0 = 4; j1 = 5; expv = 1; end
        3: begin tr = 1; j0 = 3; j1 = 3; expv = 0; end
        4: begin tr = 1; j0 = 3; j1 = 4; expv = 1; end
        default: begin tr = 0; j0 = 3; j1 = 4; expv = 0; end
      endcase
      start(0, 5, 3, 1, tr);
      fall_now(b0);
      drive_before(b0 + j0, 1'b1);
      drive_before(b0 + j1 + 1, 1'b0);
      wait_to(b0 + 6);
      chk("R8 spike vote value", sv_val[0], expv);
      chk("R8 spike sample edge", sv_cyc[0], b0 + 6);
    end

    // R9 return to idle after IDLE recessive samples, then hard sync again
    start(0, 2, 2, 1, 1'b0);
    fall_now(b0);
    drive_before(b0 + 5, 1'b1);
    wait_to(b0 + 5 * (IDLE + 8));
    chk("R9 samples before idle", nsv, IDLE + 1);
    chk("R9 transmit points before idle", ntx, IDLE);
    chk("R9 last recessive value", sv_val[IDLE], 1);
    fall_now(b1);
    wait_to(b1 + 3);
    chk("R9 resync from idle count", nsv, IDLE + 2);
    chk("R9 resync from idle edge", sv_cyc[IDLE + 1], b1 + 3);
    chk("R9 resync from idle value", sv_val[IDLE + 1], 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule